// File: doc/BRIEF.md
# Ring-Length Pulse Counter with Compare Output

This block counts single-cycle up and down pulses into a signed two's-complement value. Counting happens only while the run input is high. On the cycle run goes high (the start), the block takes a copy of the ring-mode flag and the ring length and keeps that copy for the whole run. Changes to those inputs during a run have no effect until the next start.

With ring mode captured as on, the count stays between 0 and the ring length minus 1 and wraps at both ends. A count that lies outside that range at the start is clamped to the nearest limit. With ring mode off, the count covers the full signed range and wraps in two's complement.

A compare unit checks the updated count against a compare value on every clock edge while running. On a match it sets or clears a held output bit, as chosen by a select input. The bit keeps its level until the next match or a reset.

Top module: `ring_pulse_counter`

## Requirements
- R1: After reset, `count` is 0 and `match_q` is 0.
- R2: While `run` is low, up and down pulses are ignored and `count` holds its value.
- R3: While running, an `up_pulse` alone adds 1 to `count` and a `dn_pulse` alone subtracts 1, both in the next clock edge. Both pulses in the same cycle cancel, and `count` does not change.
- R4: With ring mode off, counting up from the signed maximum gives the signed minimum, and counting down from the minimum gives the maximum.
- R5: With ring mode on, counting up from ring length minus 1 gives 0, counting down from 0 gives ring length minus 1, and `count` never leaves the range 0 to ring length minus 1.
- R6: `ring_en` and `ring_len` are sampled only on the start edge, when `run` rises. Changes to them during a run do not affect counting.
- R7: At a start with ring mode on, a negative `count` becomes 0 and a count above ring length minus 1 becomes ring length minus 1. Pulses are ignored on the start edge.
- R8: A `ring_len` of 0 behaves as 1, so `count` stays at 0 in ring mode.
- R9: While `run` and `cmp_en` are high, if the updated count equals `cmp_val`, `match_q` takes the value of `cmp_set` (1 sets, 0 clears) on that same clock edge.
- R10: While `cmp_en` is low or `run` is low, `match_q` holds its value even when `count` equals `cmp_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Counter run enable; a rising edge is a start |
| up_pulse | input | 1 | Count-up pulse, one per cycle |
| dn_pulse | input | 1 | Count-down pulse, one per cycle |
| ring_en | input | 1 | Ring mode request, captured at start |
| ring_len | input | W | Ring length (unsigned), captured at start |
| cmp_val | input | W | Compare value |
| cmp_set | input | 1 | Match action: 1 sets, 0 clears the output bit |
| cmp_en | input | 1 | Compare enable |
| count | output | W | Current count, two's complement |
| match_q | output | 1 | Held match-driven bit |

## Verification
The bench builds the counter with W = 8. At that width, the signed wrap between +127 and -128 can be reached with about 130 pulses. The clamp is tested from both a negative count and a count above the ring limit. Small ring lengths of 5, 6 and 0 test wrap-around at both ends of the ring and the length-0 case within a few cycles each.

// File: rtl/ring_pulse_counter.sv
module ring_pulse_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         up_pulse,
  input  logic         dn_pulse,
  input  logic         ring_en,
  input  logic [W-1:0] ring_len,
  input  logic [W-1:0] cmp_val,
  input  logic         cmp_set,
  input  logic         cmp_en,
  output logic [W-1:0] count,
  output logic         match_q
);

  localparam logic [W-1:0] ONE = W'(1);

  logic         running;
  logic         ring_on;
  logic [W-1:0] lim;
  logic [W-1:0] clamped;
  logic [W-1:0] stepped;

  wire          start   = run && !running;
  wire [W-1:0]  len_eff = (ring_len == '0) ? ONE : ring_len;
  wire [W-1:0]  lim_new = len_eff - ONE;

  always_comb begin
    clamped = count;
    if (ring_en) begin
      if (count[W-1])         clamped = '0;
      else if (count > lim_new) clamped = lim_new;
    end
  end

  always_comb begin
    stepped = count;
    if (up_pulse && !dn_pulse)
      stepped = (ring_on && count == lim) ? '0 : count + ONE;
    else if (dn_pulse && !up_pulse)
      stepped = (ring_on && count == '0) ? lim : count - ONE;
  end

  wire [W-1:0] nxt = start ? clamped : (run ? stepped : count);
  wire         hit = run && cmp_en && (nxt == cmp_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      ring_on <= 1'b0;
      lim     <= '0;
      count   <= '0;
      match_q <= 1'b0;
    end else begin
      running <= run;
      if (start) begin
        ring_on <= ring_en;
        lim     <= lim_new;
      end
      count <= nxt;
      if (hit) match_q <= cmp_set;
    end
  end

endmodule

// File: rtl/ring_pulse_counter_chk.sv
module ring_pulse_counter_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         up_pulse,
  input logic         dn_pulse,
  input logic         cmp_en,
  input logic         cmp_set,
  input logic [W-1:0] cmp_val,
  input logic [W-1:0] count,
  input logic         match_q,
  input logic         running,
  input logic         ring_on,
  input logic [W-1:0] lim
);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count));

  // R3
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && running && up_pulse && dn_pulse |=> $stable(count));

  // R5
  ring_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && ring_on |-> !count[W-1] && count <= lim);

  // R6
  setting_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && running |=> $stable(lim) && $stable(ring_on));

  // R9
  match_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && cmp_en |=> (count != $past(cmp_val)) || (match_q == $past(cmp_set)));

  // R10
  match_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && cmp_en) |=> $stable(match_q));

endmodule

bind ring_pulse_counter ring_pulse_counter_chk #(.W(W)) i_chk (.*);

// File: tb/test_ring_pulse_counter.sv
`timescale 1ns/1ps
module test_ring_pulse_counter;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         run = 1'b0, up_pulse = 1'b0, dn_pulse = 1'b0;
  logic         ring_en = 1'b0, cmp_set = 1'b0, cmp_en = 1'b0;
  logic [W-1:0] ring_len = '0, cmp_val = '0;
  logic [W-1:0] count;
  logic         match_q;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ring_pulse_counter #(.W(W)) i_ring_pulse_counter (
    .clk(clk), .rst_n(rst_n), .run(run), .up_pulse(up_pulse), .dn_pulse(dn_pulse),
    .ring_en(ring_en), .ring_len(ring_len), .cmp_val(cmp_val), .cmp_set(cmp_set),
    .cmp_en(cmp_en), .count(count), .match_q(match_q));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(logic u, logic d);
    up_pulse = u; dn_pulse = d;
    @(negedge clk);
    up_pulse = 1'b0; dn_pulse = 1'b0;
  endtask

  task automatic restart(logic ren, int len);
    run = 1'b0; tick(0, 0);
    ring_en = ren; ring_len = W'(len); run = 1'b1;
    tick(1, 0);
  endtask

  task automatic t_reset();
    chk("R1 count", int'($signed(count)), 0);
    chk("R1 match", int'(match_q), 0);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 3; i++) tick(1, 0);
    tick(0, 1);
    chk("R2 idle", int'($signed(count)), 0);
  endtask

  task automatic t_basic();
    restart(0, 0);
    chk("R7 start ignores pulse", int'($signed(count)), 0);
    for (int i = 0; i < 5; i++) tick(1, 0);
    chk("R3 up", int'($signed(count)), 5);
    tick(0, 1); tick(0, 1);
    chk("R3 down", int'($signed(count)), 3);
    tick(1, 1); tick(1, 1);
    chk("R3 cancel", int'($signed(count)), 3);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 124; i++) tick(1, 0);
    chk("R4 max", int'($signed(count)), 127);
    tick(1, 0);
    chk("R4 up wrap", int'($signed(count)), -128);
    tick(0, 1);
    chk("R4 down wrap", int'($signed(count)), 127);
  endtask

  task automatic t_ring();
    restart(1, 5);
    chk("R7 clamp high", int'($signed(count)), 4);
    tick(1, 0);
    chk("R5 up wrap", int'($signed(count)), 0);
    tick(0, 1);
    chk("R5 down wrap", int'($signed(count)), 4);
    for (int i = 0; i < 3; i++) tick(1, 0);
    chk("R5 step", int'($signed(count)), 2);
    ring_len = W'(100); ring_en = 1'b0;
    for (int i = 0; i < 3; i++) tick(1, 0);
    chk("R6 latched", int'($signed(count)), 0);
  endtask

  task automatic t_clamp_low();
    restart(0, 0);
    for (int i = 0; i < 3; i++) tick(0, 1);
    chk("R4 negative", int'($signed(count)), -3);
    restart(1, 6);
    chk("R7 clamp low", int'($signed(count)), 0);
    tick(0, 1);
    chk("R5 down from 0", int'($signed(count)), 5);
  endtask

  task automatic t_zero();
    restart(1, 0);
    chk("R8 clamp", int'($signed(count)), 0);
    tick(1, 0);
    chk("R8 up", int'($signed(count)), 0);
    tick(0, 1);
    chk("R8 down", int'($signed(count)), 0);
  endtask

  task automatic t_match();
    restart(0, 0);
    cmp_val = W'(3); cmp_set = 1'b1; cmp_en = 1'b1;
    tick(1, 0); tick(1, 0);
    chk("R9 no match yet", int'(match_q), 0);
    tick(1, 0);
    chk("R9 set", int'(match_q), 1);
    tick(1, 0);
    chk("R9 held", int'(match_q), 1);
    cmp_set = 1'b0;
    tick(0, 1);
    chk("R9 clear", int'(match_q), 0);
  endtask

  task automatic t_disabled();
    cmp_en = 1'b0; cmp_set = 1'b1;
    tick(1, 0); tick(0, 1);
    chk("R10 equal count", int'($signed(count)), 3);
    chk("R10 compare off", int'(match_q), 0);
    cmp_en = 1'b1; run = 1'b0;
    tick(0, 0); tick(0, 0);
    chk("R10 stopped", int'(match_q), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_basic();
    t_wrap();
    t_ring();
    t_clamp_low();
    t_zero();
    t_match();
    t_disabled();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule